// File: doc/BRIEF.md
# Target-Time Pulse Output Generator

This block watches a free-running 64-bit system-time value and produces a timed pulse on one or more general-purpose output pins. Software programs two absolute 64-bit times: a leading-edge time and a trailing-edge time. When the time value first reaches or passes the leading-edge time, the selected pins go to their active level. When it first reaches or passes the trailing-edge time, the pins return to idle and a sticky interrupt status bit is set. Software can then program the next pair of times, typically one second later with a width below one second (120 ms is the usual default), to build a one-pulse-per-second output.

Each comparator fires only once per arming. Arming happens on a write to the control register, and writing zero to that register disarms both comparators and returns the pins to idle in the same cycle. Each of four pins has its own function select and output polarity. Only the target-output function code drives a pin; every other code leaves the pin at its idle level. When pulse mode is off, the leading-edge match gives a single-cycle strobe instead of a window.

Top module: `tt_pulse_gen`

## Requirements
- R1: After reset, every register reads 0, every pin is low and `irq` is low.
- R2: Byte offsets are: control 0x00, interrupt status 0x04, interrupt enable 0x08, lead target low/high 0x10/0x14, trail target low/high 0x18/0x1C, pin config i at 0x20+4*i. Control keeps only bits 0, 1, 2 and 8 (mask 0x107). A pin config keeps only bits [2:0] and bit 4 (mask 0x17). Target words read back as written.
- R3: With control bit 0 (lead enable) and bit 1 (pulse mode) set, on the first clock edge where the time is greater than or equal to the lead target, each pin whose function select is 1 goes to its active level. This also holds when the time steps past the target without ever equalling it.
- R4: With control bit 2 (trail enable) set, on the first clock edge where the time is greater than or equal to the trail target, the pulse ends and interrupt status bit 5 is set.
- R5: A comparator fires at most once per control write. Once it has fired, later time values cause no further edge, strobe or interrupt until control is written again.
- R6: A comparator whose enable bit is clear in the last control write never fires. With bit 0 clear, no pulse starts. With bit 2 clear, the pulse does not end and no interrupt is raised.
- R7: If the trail match happens before the lead match, or in the same cycle, within one arming, the pins stay idle for that whole arming and status bit 5 is still set.
- R8: Writing zero to control returns all pins to idle at the next edge and disarms both comparators.
- R9: Pin config bit 4 selects polarity: 0 means idle low and active high, 1 means idle high and active low.
- R10: Only function code 1 routes the target output to a pin. Codes 0, 2 to 7, and the timestamp-input code 5 all hold the pin at its idle level.
- R11: `irq` is high exactly when status bit 5 and enable bit 5 are both set. Writing 1 to status bit 5 clears it. Writing 0 there has no effect.
- R12: With pulse mode (control bit 1) clear, the lead match drives the routed pins active for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sys_time | input | 64 | Free-running system time |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data (combinational) |
| pin_out | output | 4 | Output pin levels |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is one where the function select, the polarity and the edge timing all interact on every pin in the same run, together with coarse time steps that jump past a target without landing on it. The stimulus sweeps all eight function codes across the four pins under both polarities. On each pass it moves the time value to the leading and trailing targets by step sizes that grow from pass to pass, with the targets placed in a different high word each time. Separate sequences program the trail target before the lead target, leave either enable bit clear, and run with pulse mode off so that the one-cycle strobe can be seen.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_ISTAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_IEN   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_TGT   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_PIN   = 8'h20;

  localparam int CTL_LEAD  = 0;
  localparam int CTL_PULSE = 1;
  localparam int CTL_TRAIL = 2;
  localparam int CTL_TSI   = 8;

  localparam int IRQ_BIT   = 5;
  localparam int PIN_POL   = 4;

  localparam logic [2:0] FSEL_LEAD = 3'd1;
  localparam logic [2:0] FSEL_TSI  = 3'd5;
endpackage

// File: rtl/ptg_regs.sv
module ptg_regs
  import ptg_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 32,
  parameter int TIME_W   = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [DATA_W-1:0]               rd_data,
  input  logic                            trail_evt,
  output logic                            ctrl_wr,
  output logic                            pulse_mode,
  output logic [1:0][TIME_W-1:0]          tgt,
  output logic [NUM_PINS-1:0][2:0]        pin_fsel,
  output logic [NUM_PINS-1:0]             pin_pol,
  output logic                            irq
);
  localparam int PIN_IW = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [DATA_W-1:0] CTRL_MASK =
    DATA_W'((1 << CTL_LEAD) | (1 << CTL_PULSE) | (1 << CTL_TRAIL) | (1 << CTL_TSI));

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic              ien_q, ien_d;
  logic              istat_q, istat_d;
  logic              wr_ctrl, wr_ien, wr_istat;

  assign wr_ctrl  = wr_en && (wr_addr == OFS_CTRL);
  assign wr_ien   = wr_en && (wr_addr == OFS_IEN);
  assign wr_istat = wr_en && (wr_addr == OFS_ISTAT);

  always_comb begin
    ctrl_d  = wr_data & CTRL_MASK;
    ien_d   = wr_data[IRQ_BIT];
    istat_d = trail_evt | (istat_q & ~(wr_istat & wr_data[IRQ_BIT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      ien_q   <= 1'b0;
      istat_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_d;
      if (wr_ien)  ien_q  <= ien_d;
      istat_q <= istat_d;
    end
  end

  // target slots: low word at +0, high word at +4, slots 8 bytes apart
  for (genvar s = 0; s < 2; s++) begin : g_tgt
    localparam logic [ADDR_W-1:0] LO_A = OFS_TGT + ADDR_W'(8 * s);
    localparam logic [ADDR_W-1:0] HI_A = OFS_TGT + ADDR_W'(8 * s + 4);
    logic              lo_en, hi_en;
    logic [TIME_W-1:0] tgt_q;
    assign lo_en = wr_en && (wr_addr == LO_A);
    assign hi_en = wr_en && (wr_addr == HI_A);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tgt_q <= '0;
      end else begin
        if (lo_en) tgt_q[DATA_W-1:0]      <= wr_data;
        if (hi_en) tgt_q[TIME_W-1:DATA_W] <= wr_data[TIME_W-DATA_W-1:0];
      end
    end
    assign tgt[s] = tgt_q;
  end

  logic [NUM_PINS-1:0][DATA_W-1:0] pin_rd;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    localparam logic [ADDR_W-1:0] PA = OFS_PIN + ADDR_W'(4 * i);
    logic       cfg_en;
    logic [2:0] fsel_q;
    logic       pol_q;
    assign cfg_en = wr_en && (wr_addr == PA);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fsel_q <= 3'd0;
        pol_q  <= 1'b0;
      end else if (cfg_en) begin
        fsel_q <= wr_data[2:0];
        pol_q  <= wr_data[PIN_POL];
      end
    end
    assign pin_fsel[i] = fsel_q;
    assign pin_pol[i]  = pol_q;
    always_comb begin
      pin_rd[i]          = '0;
      pin_rd[i][2:0]     = fsel_q;
      pin_rd[i][PIN_POL] = pol_q;
    end
  end

  logic [ADDR_W-1:0] rd_off;
  logic [PIN_IW-1:0] rd_idx;
  assign rd_off = rd_addr - OFS_PIN;
  assign rd_idx = rd_off[PIN_IW+1:2];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_CTRL:                     rd_data = ctrl_q;
      OFS_ISTAT:                    rd_data[IRQ_BIT] = istat_q;
      OFS_IEN:                      rd_data[IRQ_BIT] = ien_q;
      OFS_TGT:                      rd_data = tgt[0][DATA_W-1:0];
      OFS_TGT + ADDR_W'(4):         rd_data = tgt[0][TIME_W-1:DATA_W];
      OFS_TGT + ADDR_W'(8):         rd_data = tgt[1][DATA_W-1:0];
      OFS_TGT + ADDR_W'(12):        rd_data = tgt[1][TIME_W-1:DATA_W];
      default: begin
        if ((rd_off < ADDR_W'(4 * NUM_PINS)) && (rd_off[1:0] == 2'b00))
          rd_data = pin_rd[rd_idx];
      end
    endcase
  end

  assign ctrl_wr    = wr_ctrl;
  assign pulse_mode = ctrl_q[CTL_PULSE];
  assign irq        = istat_q & ien_q;

  // R4: a trailing-edge event is recorded in the sticky status bit
  a_r4_evt_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    trail_evt |=> istat_q);

  // R11: write-one clears status when no new event arrives
  a_r11_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_istat && wr_data[IRQ_BIT] && !trail_evt) |=> !istat_q);

  // R11: writing zero to the status bit leaves a set bit set
  a_r11_w0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (istat_q && !(wr_istat && wr_data[IRQ_BIT])) |=> istat_q);
endmodule

// File: rtl/ptg_cmp.sv
module ptg_cmp #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_arm,
  input  logic [TIME_W-1:0] target,
  input  logic [TIME_W-1:0] now,
  output logic              fire
);
  logic armed_q, armed_d;

  // greater-or-equal so a coarse time step cannot skip the match
  assign fire = armed_q && !load && (now >= target);

  always_comb begin
    armed_d = armed_q;
    if (load)      armed_d = load_arm;
    else if (fire) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  // R5: a comparator cannot fire on two consecutive cycles
  a_r5_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);

  // R6: loading a cleared enable keeps the comparator silent next cycle
  a_r6_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !load_arm) |=> !fire);
endmodule

// File: rtl/ptg_pulse.sv
module ptg_pulse (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_wr,
  input  logic pulse_mode,
  input  logic lead_fire,
  input  logic trail_fire,
  output logic lead_lvl,
  output logic trail_evt
);
  logic active_q, active_d;
  logic done_q, done_d;
  logic strobe_q, strobe_d;

  always_comb begin
    active_d = active_q;
    done_d   = done_q;
    strobe_d = 1'b0;
    if (ctrl_wr) begin
      active_d = 1'b0;
      done_d   = 1'b0;
    end else begin
      strobe_d = lead_fire && !pulse_mode;
      if (trail_fire) begin
        active_d = 1'b0;
        done_d   = 1'b1;
      end else if (lead_fire && pulse_mode && !done_q) begin
        active_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      strobe_q <= strobe_d;
    end
  end

  assign lead_lvl  = pulse_mode ? active_q : strobe_q;
  assign trail_evt = trail_fire;

  // R4: the trailing edge ends the pulse window
  a_r4_trail_ends: assert property (@(posedge clk) disable iff (!rst_n)
    trail_fire |=> !active_q);

  // R8: any control write returns the target output to idle
  a_r8_ctrl_idles: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !lead_lvl);

  // R12: in strobe mode the output lasts a single cycle
  a_r12_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_q && !ctrl_wr) |=> !strobe_q);
endmodule

// File: rtl/ptg_pinmux.sv
module ptg_pinmux
  import ptg_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                     lead_lvl,
  input  logic [NUM_PINS-1:0][2:0] pin_fsel,
  input  logic [NUM_PINS-1:0]      pin_pol,
  output logic [NUM_PINS-1:0]      pin_out
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_mux
    logic routed;
    assign routed     = (pin_fsel[i] == FSEL_LEAD) && lead_lvl;
    assign pin_out[i] = routed ^ pin_pol[i];
  end
endmodule

// File: rtl/tt_pulse_gen.sv
module tt_pulse_gen
  import ptg_pkg::*;
#(
  parameter int NUM_PINS = 4,
  parameter int DATA_W   = 32,
  parameter int TIME_W   = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [TIME_W-1:0]   sys_time,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_PINS-1:0] pin_out,
  output logic                irq
);
  logic rst_s1_q, rst_s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic                     rst_int_n;
  logic                     ctrl_wr, pulse_mode, trail_evt, lead_lvl;
  logic [1:0][TIME_W-1:0]   tgt;
  logic [NUM_PINS-1:0][2:0] pin_fsel;
  logic [NUM_PINS-1:0]      pin_pol;
  logic [1:0]               fire;
  logic [1:0]               arm_bit;

  assign rst_int_n  = rst_s2_q;
  assign arm_bit[0] = wr_data[CTL_LEAD];
  assign arm_bit[1] = wr_data[CTL_TRAIL];

  ptg_regs #(.NUM_PINS(NUM_PINS), .DATA_W(DATA_W), .TIME_W(TIME_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .trail_evt  (trail_evt),
    .ctrl_wr    (ctrl_wr),
    .pulse_mode (pulse_mode),
    .tgt        (tgt),
    .pin_fsel   (pin_fsel),
    .pin_pol    (pin_pol),
    .irq        (irq)
  );

  for (genvar c = 0; c < 2; c++) begin : g_cmp
    ptg_cmp #(.TIME_W(TIME_W)) cmp_i (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .load     (ctrl_wr),
      .load_arm (arm_bit[c]),
      .target   (tgt[c]),
      .now      (sys_time),
      .fire     (fire[c])
    );
  end

  ptg_pulse pulse_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ctrl_wr    (ctrl_wr),
    .pulse_mode (pulse_mode),
    .lead_fire  (fire[0]),
    .trail_fire (fire[1]),
    .lead_lvl   (lead_lvl),
    .trail_evt  (trail_evt)
  );

  ptg_pinmux #(.NUM_PINS(NUM_PINS)) mux_i (
    .lead_lvl (lead_lvl),
    .pin_fsel (pin_fsel),
    .pin_pol  (pin_pol),
    .pin_out  (pin_out)
  );

  // R7: after a trailing match the pulse window cannot open in that arming
  a_r7_no_late_lead: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fire[1] && pulse_mode) |=> (!lead_lvl || ctrl_wr));

  // R10: once a ctrl write is done, an unrouted pin sits at its polarity level
  a_r10_unrouted_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    ctrl_wr |=> (pin_out == pin_pol));
endmodule

// File: tb/tt_pulse_gen_tb_top.sv
module tt_pulse_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] sys_time;
  logic        wr_en;
  logic [7:0]  wr_addr, rd_addr;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  pin_out;
  logic        irq;

  always #4 clk = ~clk;

  tt_pulse_gen dut_i (
    .clk(clk), .rst_n(rst_n), .sys_time(sys_time),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .pin_out(pin_out), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [2:0] m_fsel [4];
  logic       m_pol  [4];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    if (a >= 8'h20 && a < 8'h30) begin
      m_fsel[(a - 8'h20) >> 2] = d[2:0];
      m_pol[(a - 8'h20) >> 2]  = d[4];
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic step_to(input logic [63:0] t);
    sys_time = t;
    @(negedge clk);
  endtask

  task automatic set_tgt(input logic [63:0] t0, input logic [63:0] t1);
    wr(8'h10, t0[31:0]); wr(8'h14, t0[63:32]);
    wr(8'h18, t1[31:0]); wr(8'h1C, t1[63:32]);
  endtask

  function automatic logic [3:0] exp_pins(input logic act);
    logic [3:0] e;
    for (int p = 0; p < 4; p++) e[p] = ((m_fsel[p] == 3'd1) && act) ^ m_pol[p];
    return e;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [63:0] base, t0, t1;
    for (int p = 0; p < 4; p++) begin m_fsel[p] = 3'd0; m_pol[p] = 1'b0; end
    rst_n = 1'b0; sys_time = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk("R1 pins", pin_out, 4'h0);
    chk("R1 irq", irq, 1'b0);
    for (int a = 0; a < 48; a += 4) begin
      rd(a[7:0], d); chk("R1 reg", d, 32'h0);
    end

    // R2: readback and masks
    wr(8'h10, 32'hDEAD_BEEF); wr(8'h14, 32'h0123_4567);
    wr(8'h18, 32'hCAFE_F00D); wr(8'h1C, 32'h89AB_CDEF);
    rd(8'h10, d); chk("R2 t0lo", d, 32'hDEAD_BEEF);
    rd(8'h14, d); chk("R2 t0hi", d, 32'h0123_4567);
    rd(8'h18, d); chk("R2 t1lo", d, 32'hCAFE_F00D);
    rd(8'h1C, d); chk("R2 t1hi", d, 32'h89AB_CDEF);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h2C, d); chk("R2 pincfg mask", d, 32'h17);
    wr(8'h2C, 32'h0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d); chk("R2 ctrl mask", d, 32'h107);
    wr(8'h00, 32'h0);
    wr(8'h08, 32'h20);
    rd(8'h08, d); chk("R2 ien", d, 32'h20);

    // R3 R4 R5 R9 R10: sweep codes and polarities, coarse steps
    for (int pol = 0; pol < 2; pol++) begin
      for (int c = 0; c < 8; c++) begin
        int k;
        k = pol * 8 + c;
        wr(8'h00, 32'h0);
        for (int p = 0; p < 4; p++)
          wr(8'h20 + 8'(4 * p), {27'd0, 1'(pol ^ (p & 1)), 1'b0, 3'((c + p) % 8)});
        base = (64'(k + 1) << 32) + 64'h100;
        t0 = base + 64'd100;
        t1 = t0 + 64'd40 + 64'(k * 10);
        step_to(base);
        set_tgt(t0, t1);
        wr(8'h04, 32'h20);
        wr(8'h00, 32'h7);
        chk("R10 R9 idle after arm", pin_out, exp_pins(1'b0));
        step_to(t0 - 64'd1);
        chk("R3 before lead", pin_out, exp_pins(1'b0));
        step_to(t0 + 64'(k % 5));
        chk("R3 R9 R10 lead edge", pin_out, exp_pins(1'b1));
        step_to(t0 + 64'd20);
        chk("R3 window held", pin_out, exp_pins(1'b1));
        chk("R4 no irq in window", irq, 1'b0);
        step_to(t1 + 64'(k % 3));
        chk("R4 trail edge", pin_out, exp_pins(1'b0));
        chk("R4 R11 irq", irq, 1'b1);
        step_to(t1 + 64'd1000);
        chk("R5 stays idle", pin_out, exp_pins(1'b0));
      end
    end

    // pins 0 and 2 routed, active high; pins 1 and 3 active-low routed
    wr(8'h20, 32'h01); wr(8'h24, 32'h11); wr(8'h28, 32'h01); wr(8'h2C, 32'h11);
    base = 64'h50_0000_0000;

    // R7: trail target earlier than lead
    wr(8'h00, 32'h0); step_to(base);
    set_tgt(base + 64'd1000, base + 64'd500);
    wr(8'h04, 32'h20); wr(8'h00, 32'h7);
    step_to(base + 64'd600);
    chk("R7 idle at trail", pin_out, 4'b1010);
    chk("R7 irq", irq, 1'b1);
    step_to(base + 64'd1100);
    chk("R7 lead after trail ignored", pin_out, 4'b1010);

    // R7: both match in same cycle
    base = base + 64'd10000;
    wr(8'h00, 32'h0); step_to(base);
    set_tgt(base + 64'd10, base + 64'd20);
    wr(8'h04, 32'h20); wr(8'h00, 32'h7);
    step_to(base + 64'd30);
    chk("R7 same cycle idle", pin_out, 4'b1010);
    chk("R7 same cycle irq", irq, 1'b1);

    // R6: lead disabled
    base = base + 64'd10000;
    wr(8'h00, 32'h0); step_to(base);
    set_tgt(base + 64'd10, base + 64'd20);
    wr(8'h04, 32'h20); wr(8'h00, 32'h6);
    step_to(base + 64'd15);
    chk("R6 no lead", pin_out, 4'b1010);
    step_to(base + 64'd25);
    chk("R6 trail still irq", irq, 1'b1);

    // R6: trail disabled, R8 control zero
    base = base + 64'd10000;
    wr(8'h00, 32'h0); step_to(base);
    set_tgt(base + 64'd10, base + 64'd20);
    wr(8'h04, 32'h20); wr(8'h00, 32'h3);
    step_to(base + 64'd12);
    chk("R6 lead active", pin_out, 4'b0101);
    step_to(base + 64'd30);
    chk("R6 no trail pin", pin_out, 4'b0101);
    chk("R6 no trail irq", irq, 1'b0);
    wr(8'h00, 32'h0);
    chk("R8 zero ctrl idles", pin_out, 4'b1010);
    step_to(base + 64'd5000);
    chk("R8 disarmed", pin_out, 4'b1010);
    chk("R8 no irq", irq, 1'b0);

    // R8: zero write mid window, later trail time does nothing
    base = base + 64'd10000;
    step_to(base);
    set_tgt(base + 64'd10, base + 64'd50);
    wr(8'h00, 32'h7);
    step_to(base + 64'd11);
    chk("R8 window open", pin_out, 4'b0101);
    wr(8'h00, 32'h0);
    chk("R8 cut window", pin_out, 4'b1010);
    step_to(base + 64'd60);
    chk("R8 trail disarmed", irq, 1'b0);

    // R12: strobe mode
    base = base + 64'd10000;
    step_to(base);
    set_tgt(base + 64'd10, base + 64'd90);
    wr(8'h00, 32'h5);
    step_to(base + 64'd10);
    chk("R12 strobe high", pin_out, 4'b0101);
    step_to(base + 64'd11);
    chk("R12 strobe one cycle", pin_out, 4'b1010);
    step_to(base + 64'd50);
    chk("R5 R12 no second strobe", pin_out, 4'b1010);
    step_to(base + 64'd95);
    chk("R12 trail irq", irq, 1'b1);

    // R11: enable gating and write-one-to-clear
    wr(8'h08, 32'h0);
    chk("R11 masked", irq, 1'b0);
    rd(8'h04, d); chk("R11 status sticky", d, 32'h20);
    wr(8'h08, 32'h20);
    chk("R11 unmasked", irq, 1'b1);
    wr(8'h04, 32'hFFFF_FFDF);
    rd(8'h04, d); chk("R11 write zero keeps", d, 32'h20);
    wr(8'h04, 32'h20);
    rd(8'h04, d); chk("R11 w1c", d, 32'h0);
    chk("R11 irq dropped", irq, 1'b0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule